// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block receives asynchronous serial frames of one start bit, eight or nine data bits sent least significant bit first, and one stop bit. The line is sampled sixteen times per bit. The sample rate comes from a programmable divisor, so one bit lasts 16 × (divisor + 1) clock cycles. The start bit and every data and stop bit are decided by a three-sample majority vote around the bit centre. A completed word is moved into a receive buffer and a receive flag is raised.

The block supports multiprocessor networks. In nine-bit mode the ninth bit tags a frame as an address (1) or as data (0). While address detection is on, data frames are dropped without any trace, and only address frames reach the buffer. Software reaches the block through a small register bus. The bus has a control/status register, the data buffer, the divisor, and a read-only transmit status register.

Top module: `uart9_rx`

## Requirements
- R1: After reset, address 0 (control/status) reads 0x00, address 1 (data) reads 0x00, address 2 (divisor) reads 0x00, address 3 (transmit status) reads 0x02, and `rx_flag` is 0.
- R2: One bit lasts 16 × (divisor + 1) clock cycles. Frames sent at that rate are received correctly for divisor values 0, 1 and 3.
- R3: In nine-bit mode, data bits 0..7 of a received frame appear at address 1 and data bit 8 appears at control bit 0. `rx_flag` rises when the frame is stored.
- R4: With control bit 6 (nine-bit enable) clear, a frame carries 8 data bits and control bit 0 reads 0. Control bit 3 (address detect) then has no effect.
- R5: With control bits 6 and 3 both set, a frame whose ninth bit is 0 leaves the data register, control bits 2..0 and `rx_flag` unchanged.
- R6: With control bits 6 and 3 both set, a frame whose ninth bit is 1 is stored and raises `rx_flag`.
- R7: With control bit 3 clear, frames whose ninth bit is 0 are stored normally.
- R8: A bus read of address 1 clears `rx_flag` on the following clock edge.
- R9: A stored frame whose stop bit is sampled as 0 sets control bit 2 (framing error). The frame's data is still stored. The next stored frame with a valid stop bit clears control bit 2.
- R10: A frame that would be stored while `rx_flag` is still set sets control bit 1 (overrun). That frame is discarded, and the data register keeps the older word.
- R11: Control bit 4 (continuous receive) and control bit 7 (port enable) must both be set for reception. While bit 4 is clear, the overrun bit reads 0 and frames on the line are ignored.
- R12: A low pulse on `rxd` shorter than a quarter bit is rejected as a false start. It produces no frame and no flag.
- R13: Writes to address 0 update bits 7..3 only. Bits 2..0 are read-only status, and bit 5 is stored and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on address 1) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rx_flag | output | 1 | Receive flag, a word is waiting in the buffer |

## Verification
The main function is tried with four kinds of traffic, and each separates a different mistake.
- Mixed address and data words with detection off and then on show whether the filter drops exactly the data frames and nothing else.
- Two back-to-back words with no read in between separate a correct overrun from a silent overwrite.
- A frame with a low stop bit, followed by a clean frame, shows that the framing error is both set and later cleared.
- Eight-bit frames sent with detection left on, a short start glitch, and frames at three divisor values show the frame length, the start-confirmation vote and the bit timing.

// File: rtl/uart9rx_pkg.sv
package uart9rx_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_DIV  = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_STOP
  } frame_st_e;

  typedef struct packed {
    logic [8:0] word;
    logic       stop_ok;
  } frame_t;

  localparam logic [7:0] STAT_RESET = 8'h02;

endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: with a non-zero divisor two ticks are never adjacent
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div != $past(div)));

endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart9rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   tick,
  input  logic   rxd,
  input  logic   nine_en,
  output logic   done,
  output frame_t frm
);

  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] MID  = PH_W'(OVS / 2);
  localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxs;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= rxd;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rxs = sync_q[SYNC_STAGES-1];

  frame_st_e       st_q, st_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic [3:0]      bitcnt_q, bitcnt_d;
  logic [8:0]      sh_q, sh_d;
  logic [1:0]      hist_q, hist_d;
  logic            vote, at_mid;
  logic [PH_W-1:0] phase_inc;
  logic [3:0]      last_bit;

  always_comb begin
    vote      = (hist_q[1] & hist_q[0]) | (hist_q[1] & rxs) | (hist_q[0] & rxs);
    at_mid    = (phase_q == MID);
    phase_inc = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    last_bit  = nine_en ? 4'd8 : 4'd7;

    st_d     = st_q;
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    sh_d     = sh_q;
    hist_d   = hist_q;
    done     = 1'b0;

    if (!run) begin
      st_d   = FR_IDLE;
      hist_d = 2'b11;
    end else if (tick) begin
      hist_d = {hist_q[0], rxs};
      case (st_q)
        FR_IDLE: begin
          if (hist_q[0] && !rxs) begin
            st_d    = FR_START;
            phase_d = PH_W'(1);
          end
        end
        FR_START: begin
          phase_d = phase_inc;
          if (at_mid) begin
            if (vote) st_d = FR_IDLE;
            else begin
              st_d     = FR_DATA;
              bitcnt_d = '0;
            end
          end
        end
        FR_DATA: begin
          phase_d = phase_inc;
          if (at_mid) begin
            sh_d     = {vote, sh_q[8:1]};
            bitcnt_d = bitcnt_q + 1'b1;
            if (bitcnt_q == last_bit) st_d = FR_STOP;
          end
        end
        FR_STOP: begin
          phase_d = phase_inc;
          if (at_mid) begin
            done = 1'b1;
            st_d = FR_IDLE;
          end
        end
        default: st_d = FR_IDLE;
      endcase
    end

    frm.word    = nine_en ? sh_q : {1'b0, sh_q[8:1]};
    frm.stop_ok = vote;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FR_IDLE;
      phase_q  <= '0;
      bitcnt_q <= '0;
      sh_q     <= '0;
      hist_q   <= 2'b11;
    end else begin
      st_q     <= st_d;
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      sh_q     <= sh_d;
      hist_q   <= hist_d;
    end
  end

  // R11: a disabled receiver is parked in idle
  a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (st_q == FR_IDLE));

  // R12: a frame is only entered after the start state
  a_r12_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_DATA && $past(st_q) != FR_DATA) |-> $past(st_q) == FR_START);

endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import uart9rx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             done,
  input  frame_t           frm,
  output logic             flag,
  output logic [DIV_W-1:0] div,
  output logic             run,
  output logic             nine_en
);

  logic             port_q, nine_q, single_q, cont_q, adet_q;
  logic             port_d, nine_d, single_d, cont_d, adet_d;
  logic             ferr_q, oerr_q, b8_q, flag_q;
  logic             ferr_d, oerr_d, b8_d, flag_d;
  logic [7:0]       data_q, data_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_ctrl, wr_div, rd_data;
  logic             drop, flag_eff, load, ovr;

  always_comb begin
    wr_ctrl  = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    wr_div   = bus_sel && bus_wr && (bus_addr == REG_DIV);
    rd_data  = bus_sel && bus_rd && (bus_addr == REG_DATA);
    drop     = nine_q && adet_q && !frm.word[8];
    flag_eff = flag_q && !rd_data;
    load     = done && !drop && !flag_eff;
    ovr      = done && !drop && flag_eff;

    port_d   = wr_ctrl ? bus_wdata[7] : port_q;
    nine_d   = wr_ctrl ? bus_wdata[6] : nine_q;
    single_d = wr_ctrl ? bus_wdata[5] : single_q;
    cont_d   = wr_ctrl ? bus_wdata[4] : cont_q;
    adet_d   = wr_ctrl ? bus_wdata[3] : adet_q;
    div_d    = wr_div  ? bus_wdata[DIV_W-1:0] : div_q;

    flag_d = load ? 1'b1 : flag_eff;
    data_d = load ? frm.word[7:0] : data_q;
    b8_d   = load ? frm.word[8] : b8_q;
    ferr_d = load ? !frm.stop_ok : ferr_q;
    if (!cont_q)  oerr_d = 1'b0;
    else if (ovr) oerr_d = 1'b1;
    else          oerr_d = oerr_q;

    case (bus_addr)
      REG_CTRL: bus_rdata = {port_q, nine_q, single_q, cont_q, adet_q, ferr_q, oerr_q, b8_q};
      REG_DATA: bus_rdata = data_q;
      REG_DIV:  bus_rdata = 8'(div_q);
      default:  bus_rdata = STAT_RESET;
    endcase

    flag    = flag_q;
    div     = div_q;
    run     = port_q && cont_q;
    nine_en = nine_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= 1'b0; nine_q <= 1'b0; single_q <= 1'b0; cont_q <= 1'b0; adet_q <= 1'b0;
      ferr_q <= 1'b0; oerr_q <= 1'b0; b8_q <= 1'b0; flag_q <= 1'b0;
      data_q <= '0;   div_q  <= '0;
    end else begin
      port_q <= port_d; nine_q <= nine_d; single_q <= single_d; cont_q <= cont_d; adet_q <= adet_d;
      ferr_q <= ferr_d; oerr_q <= oerr_d; b8_q <= b8_d; flag_q <= flag_d;
      data_q <= data_d; div_q  <= div_d;
    end
  end

  // R3: the flag only rises after a completed frame
  a_r3_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(done));

  // R5: a filtered data frame never raises the flag
  a_r5_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nine_q && adet_q && !frm.word[8] && !flag_q) |=> !flag_q);

  // R8: reading the buffer clears the flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !flag_q);

  // R10: a frame landing on a full buffer flags overrun and is lost
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr) |=> (oerr_q && $stable(data_q)));

  // R11: continuous receive off holds overrun clear
  a_r11_oerr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_q |=> !oerr_q);

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rx_flag
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             run, tick, nine_en, done;
  logic [DIV_W-1:0] div;
  frame_t           frm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rx_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_int_n), .run(run), .div(div), .tick(tick)
  );

  rx_frame #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) i_frame (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick(tick), .rxd(rxd),
    .nine_en(nine_en), .done(done), .frm(frm)
  );

  rx_regs #(.DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .frm(frm), .flag(rx_flag), .div(div), .run(run), .nine_en(nine_en)
  );

endmodule

// File: tb/test_uart9_rx.sv
`timescale 1ns/1ps
module test_uart9_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       rx_flag;

  uart9_rx i_uart9_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_flag(rx_flag)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit quiet = 1'b0;
  bit m_port, m_nine, m_sren, m_cont, m_adet, m_ferr, m_oerr, m_b8, m_flag;
  logic [7:0] m_data, m_div;

  function automatic logic [7:0] exp_ctrl();
    return {m_port, m_nine, m_sren, m_cont, m_adet, m_ferr, m_oerr, m_b8};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the flag against the model
  always @(negedge clk) if (quiet) chk("R3/R8 flag vs model", rx_flag, m_flag);

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    if (a == 2'd0) begin
      {m_port, m_nine, m_sren, m_cont, m_adet} = d[7:3];
      if (!m_cont) m_oerr = 0;
    end else if (a == 2'd2) m_div = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    if (a == 2'd1) m_flag = 0;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic send(input logic [8:0] w, input bit stop_v);
    int cpb = 16 * (int'(m_div) + 1);
    int nb = m_nine ? 9 : 8;
    bit drop;
    @(negedge clk);
    rxd = 0;
    repeat (cpb) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = w[i];
      repeat (cpb) @(negedge clk);
    end
    quiet = 0;
    rxd = stop_v;
    repeat (cpb) @(negedge clk);
    rxd = 1;
    if (!stop_v) repeat (cpb) @(negedge clk);
    #1;
    if (m_port && m_cont) begin
      drop = m_nine && m_adet && !w[8];
      if (!drop) begin
        if (m_flag) m_oerr = 1;
        else begin
          m_flag = 1; m_data = w[7:0]; m_b8 = m_nine ? w[8] : 1'b0; m_ferr = !stop_v;
        end
      end
    end
    quiet = 1;
  endtask

  task automatic verify(input string tag, input bit do_read);
    logic [7:0] v;
    rd_reg(2'd0, v); chk({tag, " ctrl"}, v, exp_ctrl());
    chk({tag, " flag"}, rx_flag, m_flag);
    if (do_read) begin
      rd_reg(2'd1, v); chk({tag, " data"}, v, m_data);
      chk({tag, " flag cleared R8"}, rx_flag, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    {m_port, m_nine, m_sren, m_cont, m_adet, m_ferr, m_oerr, m_b8, m_flag} = '0;
    m_data = 0; m_div = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    quiet = 1;

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 data reset", v, 8'h00);
    rd_reg(2'd2, v); chk("R1 div reset", v, 8'h00);
    rd_reg(2'd3, v); chk("R1 stat reset", v, 8'h02);
    chk("R1 flag reset", rx_flag, 0);

    // R13 status bits are read-only, bit 5 stored
    wr_reg(2'd0, 8'hF7);
    rd_reg(2'd0, v); chk("R13 ctrl write mask", v, 8'hF0);
    wr_reg(2'd0, 8'hD0);

    // R2 R3 divisor 0, nine-bit frame with ninth bit set
    send(9'h1A5, 1); verify("R3 div0 frame", 1);

    // R2 divisor 1
    wr_reg(2'd2, 8'h01);
    rd_reg(2'd2, v); chk("R13 div readback", v, 8'h01);
    send(9'h03C, 1); verify("R2 div1 frame", 1);

    // R5 R6 address filter
    wr_reg(2'd0, 8'hD8);
    send(9'h055, 1); verify("R5 data dropped", 0);
    rd_reg(2'd1, v); chk("R5 data unchanged", v, 8'h3C);
    send(9'h1C3, 1); verify("R6 address stored", 1);

    // R7 filter off
    wr_reg(2'd0, 8'hD0);
    send(9'h07E, 1); verify("R7 data accepted", 1);

    // R10 overrun
    send(9'h011, 1);
    send(9'h022, 1); verify("R10 overrun", 1);

    // R11 clearing continuous receive clears overrun, frames ignored
    wr_reg(2'd0, 8'hC0);
    verify("R11 oerr cleared", 0);
    send(9'h199, 1); verify("R11 ignored while off", 0);
    wr_reg(2'd0, 8'hD0);

    // R9 framing error then recovery
    send(9'h1F0, 0); verify("R9 framing error", 1);
    send(9'h001, 1); verify("R9 ferr cleared", 1);

    // R4 eight-bit mode, address detect left on
    wr_reg(2'd0, 8'h98);
    send(9'h0AB, 1); verify("R4 eight-bit", 1);
    wr_reg(2'd0, 8'hD0);

    // R12 short start glitch
    @(negedge clk); rxd = 0;
    repeat (4 * (int'(m_div) + 1)) @(negedge clk);
    rxd = 1;
    repeat (64) @(negedge clk);
    verify("R12 glitch rejected", 0);
    rd_reg(2'd1, v); chk("R12 data unchanged", v, 8'hAB);

    // R2 divisor 3
    wr_reg(2'd2, 8'h03);
    send(9'h15A, 1); verify("R2 div3 frame", 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule